// File: doc/BRIEF.md
# Flash Program and Sector-Erase Sequencer

This block turns one request, either a single-word program or a sector erase, into the bus-write sequence that an external NOR-type flash expects. It then polls the device until the operation completes or a cycle budget runs out, and returns a result code. Two command protocols are supported, chosen per request:

- **Status-register style.** Busy is read from a status bit, and failures are decoded from the other status bits.
- **Unlock-sequence style.** Each command is preceded by a two-write key, and busy shows as a bit that changes between consecutive reads.

A host presents a request for one cycle while the block is idle. `busy` then stays high until the cycle with `resp_done`, which carries `resp_code`. The flash bus is a plain single-cycle write/read port: a read returns `bus_rdata` within the same cycle that `bus_re` is high.

Program requests first read the target word. If any bit would have to go from 0 to 1, the request ends at once with a not-erased result and nothing is written.

Top module: `pe_sequencer`

## Requirements

Encodings used below:
- `req_op`: 0 means sector erase, 1 means word program.
- `req_style`: 0 means status-register style, 1 means unlock style.
- Command bytes are zero-extended to the bus width.
- Result codes: 0 ok, 1 timeout, 2 not-erased, 3 protected, 4 invalid.

- R1: A status-style erase writes, on consecutive cycles, 0x50, then 0x20, then 0xD0, all to the sector base address.
- R2: A status-style program writes 0x50, then 0x40, then the data word, all to the target address.
- R3: An unlock-style erase writes the following, in this order:
  - 0xAA to base+0x555
  - 0x55 to base+0x2AA
  - 0x80 to base+0x555
  - 0xAA to base+0x555
  - 0x55 to base+0x2AA
  - 0x30 to the base
- R4: An unlock-style program writes 0xAA to base+0x555, then 0x55 to base+0x2AA, then 0xA0 to base+0x555, then the data word to the target address.
- R5: After the last command write, the block reads the sector base once per cycle. In status style the device counts as busy while bit 7 of the read is 0.
- R6: In unlock style, the device counts as busy while bit 6 of a read differs from bit 6 of the previous poll read. The first poll read of an operation always counts as busy.
- R7: For a program request, the block first reads the target word in the cycle after acceptance. If (old AND new) differs from new, the block issues no write, and `resp_done` with code 2 follows in the next cycle.
- R8: With timeout T, at most T+1 poll reads are made. If the device is still busy on read T+1, the block writes the reset command to the sector base (0xFF in status style, 0xF0 in unlock style) and reports code 1.
- R9: In status style, the ready status read is decoded in this priority order:
  - bit 1 gives code 3;
  - otherwise bit 5 set with bit 4 clear gives code 2;
  - otherwise any of bits 5, 4, 3 gives code 4;
  - otherwise the code is 0.
- R10: A status-style operation that completes always ends with a write of 0xFF to the sector base. An unlock-style operation that completes ends with no further write.
- R11: Bus and handshake rules:
  - `resp_done` is a single-cycle pulse, followed by `busy` low.
  - `busy` is high from the cycle after acceptance through the `resp_done` cycle.
  - Requests presented while busy are ignored.
  - No bus access happens while idle, and a write and a read never share a cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 1 | 0 erase, 1 program |
| req_style | input | 1 | 0 status-register style, 1 unlock style |
| req_sector | input | AW | Sector base word address |
| req_addr | input | AW | Target word address for program |
| req_data | input | DW | Word to program |
| req_timeout | input | TW | Poll budget in cycles |
| busy | output | 1 | Operation in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_code | output | 3 | Result code, valid with resp_done |
| bus_we | output | 1 | Flash write strobe |
| bus_re | output | 1 | Flash read strobe |
| bus_addr | output | AW | Flash word address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data, same cycle as bus_re |

## Verification

A wrong sequence step or step counter shows up at once on the bus: the first command write with the wrong address or data is flagged in the cycle it appears. Corruption in the poll logic (a stale bit-6 sample, or a miscounted budget) moves the cycle of `resp_done` and the cycle of the closing reset write. The bench therefore predicts the exact done cycle and checks `busy` and `resp_done` in every cycle of every operation. A status-decode fault can only appear as a wrong `resp_code` in the single done cycle, so each decode priority case gets its own operation.

// File: rtl/pe_pkg.sv
// Shared types and constants of the program/erase sequencer.
// Assumes command bytes are zero-extended onto a bus of 8 bits or more.
package pe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ISSUE,
        S_POLL,
        S_RESET,
        S_FINISH
    } seq_state_e;

    localparam logic [2:0] RC_OK         = 3'd0;
    localparam logic [2:0] RC_TIMEOUT    = 3'd1;
    localparam logic [2:0] RC_NOT_ERASED = 3'd2;
    localparam logic [2:0] RC_PROTECTED  = 3'd3;
    localparam logic [2:0] RC_INVALID    = 3'd4;

    // status-register style commands
    localparam logic [7:0] SR_CLEAR   = 8'h50;
    localparam logic [7:0] SR_ERASE   = 8'h20;
    localparam logic [7:0] SR_CONFIRM = 8'hD0;
    localparam logic [7:0] SR_PROGRAM = 8'h40;
    localparam logic [7:0] SR_ARRAY   = 8'hFF;

    // unlock-sequence style commands
    localparam logic [7:0] UL_KEY_1   = 8'hAA;
    localparam logic [7:0] UL_KEY_2   = 8'h55;
    localparam logic [7:0] UL_ERASE   = 8'h80;
    localparam logic [7:0] UL_SECTOR  = 8'h30;
    localparam logic [7:0] UL_PROGRAM = 8'hA0;
    localparam logic [7:0] UL_ARRAY   = 8'hF0;

    localparam logic [11:0] UL_OFS_KEY1 = 12'h555;
    localparam logic [11:0] UL_OFS_KEY2 = 12'h2AA;

endpackage

// File: rtl/pe_step_gen.sv
// Command step generator: maps (style, operation, step index) to one bus
// write and flags the last step of the command sequence.
// Assumes the index never passes the last step of the selected sequence.
module pe_step_gen
    import pe_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic          unlock_style,
    input  logic          is_program,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] sector,
    input  logic [AW-1:0] target,
    input  logic [DW-1:0] data,
    output logic [AW-1:0] step_addr,
    output logic [DW-1:0] step_data,
    output logic          step_last
);

    logic [AW-1:0] key1_addr;
    logic [AW-1:0] key2_addr;

    assign key1_addr = sector + AW'(UL_OFS_KEY1);
    assign key2_addr = sector + AW'(UL_OFS_KEY2);

    // Purpose: select the address/data pair for the current sequence step.
    always_comb begin
        step_addr = sector;
        step_data = '0;
        step_last = 1'b0;
        unique case ({unlock_style, is_program})
            2'b00: begin
                case (idx)
                    IW'(0):  step_data = DW'(SR_CLEAR);
                    IW'(1):  step_data = DW'(SR_ERASE);
                    default: begin
                        step_data = DW'(SR_CONFIRM);
                        step_last = 1'b1;
                    end
                endcase
            end
            2'b01: begin
                step_addr = target;
                case (idx)
                    IW'(0):  step_data = DW'(SR_CLEAR);
                    IW'(1):  step_data = DW'(SR_PROGRAM);
                    default: begin
                        step_data = data;
                        step_last = 1'b1;
                    end
                endcase
            end
            2'b10: begin
                case (idx)
                    IW'(0), IW'(3): begin
                        step_addr = key1_addr;
                        step_data = DW'(UL_KEY_1);
                    end
                    IW'(1), IW'(4): begin
                        step_addr = key2_addr;
                        step_data = DW'(UL_KEY_2);
                    end
                    IW'(2): begin
                        step_addr = key1_addr;
                        step_data = DW'(UL_ERASE);
                    end
                    default: begin
                        step_addr = sector;
                        step_data = DW'(UL_SECTOR);
                        step_last = 1'b1;
                    end
                endcase
            end
            default: begin
                case (idx)
                    IW'(0): begin
                        step_addr = key1_addr;
                        step_data = DW'(UL_KEY_1);
                    end
                    IW'(1): begin
                        step_addr = key2_addr;
                        step_data = DW'(UL_KEY_2);
                    end
                    IW'(2): begin
                        step_addr = key1_addr;
                        step_data = DW'(UL_PROGRAM);
                    end
                    default: begin
                        step_addr = target;
                        step_data = data;
                        step_last = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/pe_busy_detect.sv
// Busy detector for both protocols.
// Status style: busy while the ready bit is low.
// Unlock style: busy while the toggle bit differs from the previous poll read.
// Assumes clear is pulsed once per operation before the first sample.
module pe_busy_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic unlock_style,
    input  logic ready_bit,
    input  logic toggle_bit,
    output logic dev_busy
);

    logic have_prev_q;
    logic prev_toggle_q;

    // Purpose: remember the toggle bit of the last poll read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q   <= 1'b0;
            prev_toggle_q <= 1'b0;
        end else if (clear) begin
            have_prev_q   <= 1'b0;
        end else if (sample) begin
            have_prev_q   <= 1'b1;
            prev_toggle_q <= toggle_bit;
        end
    end

    // Purpose: combine the current read with history into a busy flag.
    always_comb begin
        if (unlock_style) begin
            dev_busy = !have_prev_q || (toggle_bit != prev_toggle_q);
        end else begin
            dev_busy = !ready_bit;
        end
    end

endmodule

// File: rtl/pe_timer.sv
// Poll budget counter: loaded at request acceptance and decremented per
// busy poll cycle. Assumes dec is never raised while expired is high.
module pe_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          dec,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Purpose: hold the remaining poll budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pe_status_decode.sv
// Maps the final status read to a result code. Only status style reports
// device errors; unlock style completion is always ok.
module pe_status_decode
    import pe_pkg::*;
(
    input  logic       unlock_style,
    input  logic       erase_fail,
    input  logic       lock_fail,
    input  logic       low_volt,
    input  logic       locked,
    output logic [2:0] code
);

    // Purpose: prioritised error decode.
    always_comb begin
        if (unlock_style) begin
            code = RC_OK;
        end else if (locked) begin
            code = RC_PROTECTED;
        end else if (erase_fail && !lock_fail) begin
            code = RC_NOT_ERASED;
        end else if (erase_fail || lock_fail || low_volt) begin
            code = RC_INVALID;
        end else begin
            code = RC_OK;
        end
    end

endmodule

// File: rtl/pe_sequencer.sv
// Program/erase sequencer top.
// Accepts one request while idle, optionally checks that the target is
// erased, issues the command writes, polls until ready or out of budget,
// writes the reset command where required and pulses resp_done.
// Assumes the flash returns read data in the same cycle as bus_re.
module pe_sequencer
    import pe_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic          req_style,
    input  logic [AW-1:0] req_sector,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] req_timeout,
    output logic          busy,
    output logic          resp_done,
    output logic [2:0]    resp_code,
    output logic          bus_we,
    output logic          bus_re,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    localparam int IW = 3;

    seq_state_e    state_q;
    logic          prog_q;
    logic          unlock_q;
    logic [AW-1:0] sector_q;
    logic [AW-1:0] target_q;
    logic [DW-1:0] data_q;
    logic [IW-1:0] idx_q;
    logic [2:0]    code_q;

    logic          accept;
    logic          polling;
    logic [AW-1:0] step_addr;
    logic [DW-1:0] step_data;
    logic          step_last;
    logic          dev_busy;
    logic          expired;
    logic [2:0]    status_code;
    logic          not_erased;

    assign accept     = (state_q == S_IDLE) && req_valid;
    assign polling    = (state_q == S_POLL);
    assign not_erased = ((bus_rdata & data_q) != data_q);

    pe_step_gen #(.AW(AW), .DW(DW), .IW(IW)) u_steps (
        .unlock_style (unlock_q),
        .is_program   (prog_q),
        .idx          (idx_q),
        .sector       (sector_q),
        .target       (target_q),
        .data         (data_q),
        .step_addr    (step_addr),
        .step_data    (step_data),
        .step_last    (step_last)
    );

    pe_busy_detect u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (accept),
        .sample       (polling),
        .unlock_style (unlock_q),
        .ready_bit    (bus_rdata[7]),
        .toggle_bit   (bus_rdata[6]),
        .dev_busy     (dev_busy)
    );

    pe_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_timeout),
        .dec      (polling && dev_busy && !expired),
        .expired  (expired)
    );

    pe_status_decode u_decode (
        .unlock_style (unlock_q),
        .erase_fail   (bus_rdata[5]),
        .lock_fail    (bus_rdata[4]),
        .low_volt     (bus_rdata[3]),
        .locked       (bus_rdata[1]),
        .code         (status_code)
    );

    // Purpose: latch the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q   <= 1'b0;
            unlock_q <= 1'b0;
            sector_q <= '0;
            target_q <= '0;
            data_q   <= '0;
        end else if (accept) begin
            prog_q   <= req_op;
            unlock_q <= req_style;
            sector_q <= req_sector;
            target_q <= req_addr;
            data_q   <= req_data;
        end
    end

    // Purpose: sequence state, step index and result code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            code_q  <= RC_OK;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= '0;
                        code_q  <= RC_OK;
                        state_q <= req_op ? S_CHECK : S_ISSUE;
                    end
                end
                S_CHECK: begin
                    if (not_erased) begin
                        code_q  <= RC_NOT_ERASED;
                        state_q <= S_FINISH;
                    end else begin
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (step_last) begin
                        state_q <= S_POLL;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                S_POLL: begin
                    if (!dev_busy) begin
                        code_q  <= status_code;
                        state_q <= unlock_q ? S_FINISH : S_RESET;
                    end else if (expired) begin
                        code_q  <= RC_TIMEOUT;
                        state_q <= S_RESET;
                    end
                end
                S_RESET:  state_q <= S_FINISH;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Purpose: drive the flash bus from the current state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = sector_q;
        bus_wdata = '0;
        case (state_q)
            S_CHECK: begin
                bus_re   = 1'b1;
                bus_addr = target_q;
            end
            S_ISSUE: begin
                bus_we    = 1'b1;
                bus_addr  = step_addr;
                bus_wdata = step_data;
            end
            S_POLL:  bus_re = 1'b1;
            S_RESET: begin
                bus_we    = 1'b1;
                bus_wdata = unlock_q ? DW'(UL_ARRAY) : DW'(SR_ARRAY);
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != S_IDLE);
    assign resp_done = (state_q == S_FINISH);
    assign resp_code = code_q;

endmodule

// File: rtl/pe_sequencer_chk.sv
// Port-level protocol checker for pe_sequencer, bound to every instance.
module pe_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       resp_done,
    input logic [2:0] resp_code,
    input logic       bus_we,
    input logic       bus_re
);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !busy);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_we && !bus_re && !resp_done));

    a_r11_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> (resp_code <= 3'd4));

    a_r8_timeout_after_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_code == 3'd1) |-> $past(bus_we));

endmodule

bind pe_sequencer pe_sequencer_chk u_chk (.*);

// File: tb/sim_pe_sequencer.sv
module sim_pe_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic        req_style = 1'b0;
    logic [23:0] req_sector = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [19:0] req_timeout = '0;
    logic        busy, resp_done, bus_we, bus_re;
    logic [2:0]  resp_code;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    int checks = 0;
    int fails  = 0;

    // flash model state
    bit m_chk = 1'b0;
    int m_mem = 0;
    int m_sty = 0;
    int m_cnt = 0;
    bit m_tog = 1'b0;
    int m_st  = 0;

    always #4 clk = ~clk;

    assign bus_rdata = m_chk ? 16'(m_mem) :
                       (m_sty == 0) ? ((m_cnt > 0) ? 16'h0000 : 16'(m_st | 'h80)) :
                       (m_tog ? 16'h0040 : 16'h0000);

    pe_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_style(req_style), .req_sector(req_sector), .req_addr(req_addr),
        .req_data(req_data), .req_timeout(req_timeout), .busy(busy),
        .resp_done(resp_done), .resp_code(resp_code), .bus_we(bus_we),
        .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected status-style decode
    function automatic int sr_expect(int st);
        if ((st & 'h02) != 0) return 3;
        if ((st & 'h30) == 'h20) return 2;
        if ((st & 'h38) != 0) return 4;
        return 0;
    endfunction

    // one operation with its own behavioural reference
    task automatic run_op(int op, int sty, int sec, int adr, int dat, int tmo,
                          int bsy, int st, int memv, bit inject, string tag);
        int ea[10];
        int ed[10];
        int n = 0;
        int r, polls, lat, ecode;
        int seen = 0;
        bit to, ne, rst;
        bit pend = 1'b0;
        ne = (op == 1) && ((memv & dat) != dat);
        if (sty == 0) begin
            int a = (op == 0) ? sec : adr;
            ea[0] = a; ed[0] = 'h50;
            ea[1] = a; ed[1] = (op == 0) ? 'h20 : 'h40;
            ea[2] = a; ed[2] = (op == 0) ? 'hD0 : dat;
            n = 3;
        end else if (op == 0) begin
            ea[0] = sec + 'h555; ed[0] = 'hAA;
            ea[1] = sec + 'h2AA; ed[1] = 'h55;
            ea[2] = sec + 'h555; ed[2] = 'h80;
            ea[3] = sec + 'h555; ed[3] = 'hAA;
            ea[4] = sec + 'h2AA; ed[4] = 'h55;
            ea[5] = sec;         ed[5] = 'h30;
            n = 6;
        end else begin
            ea[0] = sec + 'h555; ed[0] = 'hAA;
            ea[1] = sec + 'h2AA; ed[1] = 'h55;
            ea[2] = sec + 'h555; ed[2] = 'hA0;
            ea[3] = adr;         ed[3] = dat;
            n = 4;
        end
        r     = (sty == 0) ? bsy : bsy + 1;
        to    = (r > tmo);
        polls = to ? tmo + 1 : r + 1;
        rst   = (sty == 0) || to;
        if (ne) begin
            lat = 1; ecode = 2; n = 0;
        end else begin
            lat = op + n + polls + (rst ? 1 : 0);
            if (to) ecode = 1;
            else if (sty == 1) ecode = 0;
            else ecode = sr_expect(st);
            if (rst) begin
                ea[n] = sec; ed[n] = (sty == 0) ? 'hFF : 'hF0; n++;
            end
        end
        m_mem = memv; m_sty = sty; m_cnt = bsy; m_tog = 1'b0; m_st = st;
        m_chk = (op == 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[0]; req_style = sty[0];
        req_sector = 24'(sec); req_addr = 24'(adr); req_data = 16'(dat);
        req_timeout = 20'(tmo);
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int c = 0; c <= lat + 3; c++) begin
            @(negedge clk);
            if (pend) begin
                if (m_cnt > 0) begin m_cnt--; m_tog = ~m_tog; end
                pend = 1'b0;
            end
            chk(busy == (c <= lat), tag, $sformatf("busy at cycle %0d", c),
                int'(busy), int'(c <= lat));
            chk(resp_done == (c == lat), tag, $sformatf("done at cycle %0d", c),
                int'(resp_done), int'(c == lat));
            if (resp_done)
                chk(resp_code == 3'(ecode), tag, "result code", int'(resp_code), ecode);
            if (bus_we) begin
                if (seen < n) begin
                    chk(bus_addr == 24'(ea[seen]), tag, $sformatf("write %0d addr", seen),
                        int'(bus_addr), ea[seen]);
                    chk(bus_wdata == 16'(ed[seen]), tag, $sformatf("write %0d data", seen),
                        int'(bus_wdata), ed[seen]);
                end else begin
                    chk(1'b0, tag, "unexpected write", int'(bus_wdata), -1);
                end
                seen++;
            end
            if (bus_re && !m_chk) pend = 1'b1;
            if (c >= 1) m_chk = 1'b0;
            if (inject && c == 1) begin
                req_valid = 1'b1; req_op = ~op[0]; req_style = ~sty[0];
                req_sector = 24'h00F000;
            end
            if (inject && c == 2) req_valid = 1'b0;
        end
        chk(seen == n, tag, "write count", seen, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !resp_done && !bus_we && !bus_re, "R11", "idle after reset",
            int'({busy, resp_done, bus_we, bus_re}), 0);
        // R1 R5 R10 status erase
        run_op(0, 0, 'h4000, 'h4010, 0, 20, 3, 'h00, 0, 1'b0, "R1");
        // R2 R5 R10 status program, erased target
        run_op(1, 0, 'h8000, 'h8123, 'h1234, 20, 2, 'h00, 'hFFFF, 1'b0, "R2");
        // R3 R6 unlock erase, with an ignored request while busy (R11)
        run_op(0, 1, 'h10000, 'h10004, 0, 30, 4, 0, 0, 1'b1, "R3");
        // R4 R6 unlock program, ready on the second poll read
        run_op(1, 1, 'h2000, 'h2042, 'h00A5, 30, 0, 0, 'h00FF, 1'b0, "R4");
        // R7 not-erased, both styles
        run_op(1, 0, 'h3000, 'h3007, 'h0F0F, 20, 1, 0, 'h00F0, 1'b0, "R7");
        run_op(1, 1, 'h3000, 'h3009, 'h8001, 20, 1, 0, 'h7FFF, 1'b0, "R7");
        // R7 same bits already present is not a failure
        run_op(1, 0, 'h3000, 'h3011, 'h0F00, 20, 1, 0, 'h0F0F, 1'b0, "R7");
        // R8 timeout and budget edges
        run_op(0, 0, 'h5000, 'h5001, 0, 5, 50, 0, 0, 1'b0, "R8");
        run_op(1, 1, 'h6000, 'h6100, 'h0001, 3, 10, 0, 'hFFFF, 1'b0, "R8");
        run_op(0, 0, 'h7000, 'h7001, 0, 6, 6, 0, 0, 1'b0, "R8");
        run_op(0, 0, 'h7000, 'h7001, 0, 6, 7, 0, 0, 1'b0, "R8");
        run_op(0, 1, 'h7000, 'h7001, 0, 4, 3, 0, 0, 1'b0, "R8");
        run_op(0, 1, 'h7000, 'h7001, 0, 4, 4, 0, 0, 1'b0, "R8");
        run_op(0, 1, 'h7000, 'h7001, 0, 0, 0, 0, 0, 1'b0, "R8");
        // R9 status decode priorities
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 1, 'h30, 0, 1'b0, "R9");
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 1, 'h20, 0, 1'b0, "R9");
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 0, 'h02, 0, 1'b0, "R9");
        run_op(1, 0, 'h9000, 'h9005, 'h0003, 20, 2, 'h22, 'hFFFF, 1'b0, "R9");
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 1, 'h08, 0, 1'b0, "R9");
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 1, 'h10, 0, 1'b0, "R9");
        run_op(0, 0, 'h9000, 'h9001, 0, 20, 1, 'h44, 0, 1'b0, "R9");
        // R11 request ignored during a status program
        run_op(1, 0, 'hA000, 'hA0F0, 'h5555, 20, 5, 0, 'hFFFF, 1'b1, "R11");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule